// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block is the dependency-control logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it receives the two source register numbers of the instruction sitting in decode. It also receives the destination number, write flag and load flag of the instruction in execute, and the destination number and write flag of the instruction in memory. From these inputs it decides whether the decode instruction may advance. When it may, the block sets the operand bypass selects that the datapath muxes will use once that instruction reaches execute.

The selects are registered on the same edge that loads the decode/execute pipeline register, so they line up with the instruction they serve. The stall and bubble outputs are combinational, because they have to freeze the program counter and the fetch/decode register in the current cycle. The register file is written in the first half of a cycle and read in the second half. A producer that has reached writeback is therefore seen through the file and needs no bypass. Branches use one delay slot, so the block never squashes anything.

The parameter `LATE_BYPASS` selects the build variant. At 1, both bypass sources exist: the EX/MEM register and the MEM/WB register. At 0, the MEM/WB path is removed. A writer in the memory stage then has to be waited out, which adds a second stall cycle behind a load.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While reset is asserted, both bypass selects are 2'b00 from the first clock edge onward.
- R2: Select encoding: 2'b00 reads the register file, 2'b01 takes the EX/MEM value and 2'b10 takes the MEM/WB value. A source that matches the destination of a writer in execute produces 2'b01 on that operand one cycle later.
- R3: With `LATE_BYPASS`=1, a source that matches only the destination of a writer in memory produces 2'b10 one cycle later.
- R4: When a source matches the destinations of both the execute and the memory writer, the select is 2'b01, so the younger result wins.
- R5: Register number 0 never causes forwarding and never causes a stall.
- R6: An instruction whose write flag is low never causes forwarding and never causes a stall, even when its destination matches.
- R7: When the execute instruction is a writing load and its destination matches either decode source, `stall` and `bubble` are both high in that same cycle.
- R8: In a cycle where a stall is raised, both selects registered at the next edge are 2'b00, which is the bubble entering execute.
- R9: With `LATE_BYPASS`=0, a matching writer in memory raises `stall` and `bubble`, the select 2'b10 never appears, and a non-load writer in execute is still forwarded through 2'b01 without a stall.
- R10: With `LATE_BYPASS`=1, `stall` is raised only for the load-use case of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_a | input | REG_AW | First source register number of the decode instruction |
| id_src_b | input | REG_AW | Second source register number of the decode instruction |
| ex_dst | input | REG_AW | Destination register number of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_AW | Destination register number of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| fwd_a | output | 2 | Registered bypass select for operand A |
| fwd_b | output | 2 | Registered bypass select for operand B |
| stall | output | 1 | Hold the program counter and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The hardest case to reach is a single source register that matches the execute and memory destinations at the same time, while the execute instruction is or is not a load, and the other source matches neither stage. That case decides between priority, stall and bubble. The stimulus is a full sweep over a 2-bit register address space, covering every combination of both sources, both destinations and all three flags. One instance is built for each bypass variant. Each vector is held for one cycle: the combinational stall is checked before the edge, and the registered selects are checked after it.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              wen,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  // a producer counts only when it writes and does not target register 0
  assign hit = wen && (dst != ZERO_REG) && (dst == src);
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
  parameter int N_SRC       = 2,
  parameter bit LATE_BYPASS = 1'b1
) (
  input  logic [N_SRC-1:0] hit_ex,
  input  logic [N_SRC-1:0] hit_mem,
  input  logic             ex_load,
  output logic             stall
);
  logic load_use;

  // load data exists only after memory, so a consumer right behind waits
  assign load_use = ex_load && (|hit_ex);

  generate
    if (LATE_BYPASS) begin : g_full
      assign stall = load_use;
    end else begin : g_no_late
      // without the MEM/WB path a memory-stage producer must reach writeback
      assign stall = load_use || (|hit_mem);
    end
  endgenerate
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import pipe_hz_pkg::*;
#(
  parameter bit LATE_BYPASS = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hit_ex,
  input  logic     hit_mem,
  input  logic     stall,
  output fwd_sel_e sel
);
  fwd_sel_e sel_d;

  // the execute producer moves to EX/MEM, the memory producer to MEM/WB
  always_comb begin
    if (stall) begin
      sel_d = FWD_RF;
    end else if (hit_ex) begin
      sel_d = FWD_EXMEM;
    end else if (LATE_BYPASS && hit_mem) begin
      sel_d = FWD_MEMWB;
    end else begin
      sel_d = FWD_RF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= FWD_RF;
    end else begin
      sel <= sel_d;
    end
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import pipe_hz_pkg::*;
#(
  parameter int REG_AW      = 5,
  parameter bit LATE_BYPASS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              stall,
  output logic              bubble
);
  logic [REG_AW-1:0]  srcs [NUM_SRC];
  logic [NUM_SRC-1:0] hit_ex;
  logic [NUM_SRC-1:0] hit_mem;
  fwd_sel_e           sel_q [NUM_SRC];
  logic               hold;

  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      hz_match #(.REG_AW(REG_AW)) u_ex_cmp (
        .src (srcs[i]),
        .dst (ex_dst),
        .wen (ex_wen),
        .hit (hit_ex[i])
      );

      hz_match #(.REG_AW(REG_AW)) u_mem_cmp (
        .src (srcs[i]),
        .dst (mem_dst),
        .wen (mem_wen),
        .hit (hit_mem[i])
      );

      hz_fwd_sel #(.LATE_BYPASS(LATE_BYPASS)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .hit_ex  (hit_ex[i]),
        .hit_mem (hit_mem[i]),
        .stall   (hold),
        .sel     (sel_q[i])
      );
    end
  endgenerate

  hz_stall_detect #(
    .N_SRC       (NUM_SRC),
    .LATE_BYPASS (LATE_BYPASS)
  ) u_stall (
    .hit_ex  (hit_ex),
    .hit_mem (hit_mem),
    .ex_load (ex_load),
    .stall   (hold)
  );

  assign fwd_a  = sel_q[0];
  assign fwd_b  = sel_q[1];
  assign stall  = hold;
  assign bubble = hold;
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
  parameter int REG_AW      = 5,
  parameter bit LATE_BYPASS = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_wen,
  input logic              ex_load,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_wen,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              stall,
  input logic              bubble
);
  localparam logic [REG_AW-1:0] Z = '0;

  AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (rst)
    (ex_wen && ex_load && ex_dst != Z && (ex_dst == id_src_a || ex_dst == id_src_b))
      |-> (stall && bubble)); // R7

  AST_STALL_GIVES_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R8

  AST_ZERO_REG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (id_src_a == Z) |=> (fwd_a == 2'b00)); // R5

  AST_NON_WRITER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen) |=> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R6

  AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (rst)
    (!stall && ex_wen && mem_wen && ex_dst != Z && ex_dst == id_src_a && mem_dst == id_src_a)
      |=> (fwd_a == 2'b01)); // R4

  generate
    if (LATE_BYPASS) begin : g_full_chk
      AST_STALL_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(ex_wen && ex_load) |-> !stall); // R10
    end else begin : g_nolate_chk
      AST_NO_LATE_SELECT: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != 2'b10 && fwd_b != 2'b10)); // R9
    end
  endgenerate
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(
  .REG_AW      (REG_AW),
  .LATE_BYPASS (LATE_BYPASS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .id_src_a (id_src_a),
  .id_src_b (id_src_b),
  .ex_dst   (ex_dst),
  .ex_wen   (ex_wen),
  .ex_load  (ex_load),
  .mem_dst  (mem_dst),
  .mem_wen  (mem_wen),
  .fwd_a    (fwd_a),
  .fwd_b    (fwd_b),
  .stall    (stall),
  .bubble   (bubble)
);

// File: tb/pipe_hazard_ctl_tb.sv
module pipe_hazard_ctl_tb;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] src_a = '0, src_b = '0, ex_d = '0, mem_d = '0;
  logic          ex_w = 1'b0, ex_l = 1'b0, mem_w = 1'b0;
  logic [1:0]    fa_f, fb_f, fa_n, fb_n;
  logic          st_f, bu_f, st_n, bu_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_hazard_ctl #(.REG_AW(AW), .LATE_BYPASS(1'b1)) u_dut (
    .clk(clk), .rst(rst), .id_src_a(src_a), .id_src_b(src_b),
    .ex_dst(ex_d), .ex_wen(ex_w), .ex_load(ex_l),
    .mem_dst(mem_d), .mem_wen(mem_w),
    .fwd_a(fa_f), .fwd_b(fb_f), .stall(st_f), .bubble(bu_f));

  pipe_hazard_ctl #(.REG_AW(AW), .LATE_BYPASS(1'b0)) u_dut_nolate (
    .clk(clk), .rst(rst), .id_src_a(src_a), .id_src_b(src_b),
    .ex_dst(ex_d), .ex_wen(ex_w), .ex_load(ex_l),
    .mem_dst(mem_d), .mem_wen(mem_w),
    .fwd_a(fa_n), .fwd_b(fb_n), .stall(st_n), .bubble(bu_n));

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int hit(input int s, input int d, input int w);
    return (w != 0 && d != 0 && d == s) ? 1 : 0;
  endfunction

  function automatic int exp_stall(input int late);
    int ld_use;
    int mem_use;
    ld_use  = (ex_l && (hit(src_a, ex_d, ex_w) + hit(src_b, ex_d, ex_w)) != 0) ? 1 : 0;
    mem_use = (hit(src_a, mem_d, mem_w) + hit(src_b, mem_d, mem_w) != 0) ? 1 : 0;
    return (late != 0) ? ld_use : ((ld_use + mem_use) != 0 ? 1 : 0);
  endfunction

  function automatic int exp_sel(input int late, input int s);
    if (exp_stall(late) != 0) return 0;
    if (hit(s, ex_d, ex_w) != 0) return 1;
    if (late != 0 && hit(s, mem_d, mem_w) != 0) return 2;
    return 0;
  endfunction

  function automatic string sel_tag(input int late, input int s, input int e);
    if (exp_stall(late) != 0) return "R8";
    if (s == 0) return "R5";
    if (hit(s, ex_d, ex_w) != 0 && hit(s, mem_d, mem_w) != 0) return "R4";
    if (e == 1) return (late != 0) ? "R2" : "R9";
    if (e == 2) return "R3";
    return "R6";
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int es_f, es_n, ea, eb;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset fwd_a full", fa_f, 0);
    check("R1", "reset fwd_b full", fb_f, 0);
    check("R1", "reset fwd_a nolate", fa_n, 0);
    check("R1", "reset fwd_b nolate", fb_n, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < 2048; v++) begin
      @(negedge clk);
      src_a = v[1:0];
      src_b = v[3:2];
      ex_d  = v[5:4];
      mem_d = v[7:6];
      ex_w  = v[8];
      ex_l  = v[9];
      mem_w = v[10];
      #1;
      es_f = exp_stall(1);
      es_n = exp_stall(0);
      check((ex_w && ex_l) ? "R7" : "R10", "stall full", st_f, es_f);
      check("R7", "bubble full", bu_f, es_f);
      check("R9", "stall nolate", st_n, es_n);
      check("R9", "bubble nolate", bu_n, es_n);
      @(posedge clk);
      #1;
      ea = exp_sel(1, src_a);
      eb = exp_sel(1, src_b);
      check(sel_tag(1, src_a, ea), "fwd_a full", fa_f, ea);
      check(sel_tag(1, src_b, eb), "fwd_b full", fb_f, eb);
      ea = exp_sel(0, src_a);
      eb = exp_sel(0, src_b);
      check(sel_tag(0, src_a, ea), "fwd_a nolate", fa_n, ea);
      check(sel_tag(0, src_b, eb), "fwd_b nolate", fb_n, eb);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule